// File: doc/BRIEF.md
# Word-to-Halfword Access Splitter

This bridge sits between a host port that only issues 32-bit reads and writes and a peripheral register space built from 16-bit locations with per-byte lane enables. Each host access turns into a short, fixed train of narrow peripheral cycles. The bridge steps the peripheral address, picks the byte lanes and steers the host write bytes onto them. For reads it collects the returned bytes into one 32-bit word. It raises a single completion pulse when the train has finished.

When the host byte address is even, the word maps onto two whole halfword locations. When the address is odd, the access is still carried out rather than refused. It becomes three cycles: a single byte at the odd address, a full halfword at the next location, and a single byte at the even address after that. These three cycles touch three distinct locations.

Byte order is big-endian. Host byte 0 is the most significant byte of the word. An even peripheral byte address maps to lane [15:8], and an odd one maps to lane [7:0]. The host request is taken only while the bridge is idle. Address, direction and write data are registered when the request is taken, so the host may change its inputs while the train is running.

Top module: `hw_split_bridge`

## Requirements
- R1: After reset, and immediately when reset is asserted during an access, the bridge is idle: `pm_sel` = 0, `pm_be` = 2'b00 and `hb_done` = 0.
- R2: A host access at an even byte address A issues exactly two peripheral cycles. The first cycle uses `pm_addr` = A and the second uses A+2, both with `pm_be` = 2'b11. Halfword indexes wrap modulo the address space.
- R3: A host access at an odd byte address A issues exactly three peripheral cycles, with (`pm_addr`, `pm_be`) equal to (A, 2'b01), then (A+1, 2'b11), then (A+3, 2'b10). `pm_be[1]` enables lane [15:8] and `pm_be[0]` enables lane [7:0]. Only the first cycle carries an odd `pm_addr`.
- R4: On an even-address write of word W, `pm_wdata` is W[31:16] in the first cycle and W[15:0] in the second.
- R5: On an odd-address write of word W, `pm_wdata` is {8'h00, W[31:24]}, then W[23:8], then {W[7:0], 8'h00}. A lane that is not enabled is driven with zeros.
- R6: An even-address read returns `hb_rdata` = {first cycle data[15:0], second cycle data[15:0]}.
- R7: An odd-address read returns `hb_rdata` = {first data[7:0], second data[15:0], third data[15:8]}.
- R8: While `pm_sel` is high and `pm_ready` is low, `pm_sel`, `pm_we`, `pm_addr`, `pm_be` and `pm_wdata` hold their values. The next cycle starts only after `pm_ready` has been seen.
- R9: `hb_done` is high for exactly one clock, in the cycle after the last peripheral cycle's `pm_ready`. On reads, `hb_rdata` holds the assembled word in that cycle.
- R10: `hb_req` has no effect while an access is in progress. Changes to `hb_addr`, `hb_we` and `hb_wdata` after acceptance do not alter the running access.
- R11: `pm_we` equals the direction captured at acceptance for every peripheral cycle of the access (1 = write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_req | input | 1 | Host access request, taken when idle |
| hb_we | input | 1 | Host direction, 1 = write |
| hb_addr | input | ADDR_W | Host byte address |
| hb_wdata | input | 32 | Host write word, byte 0 in [31:24] |
| hb_done | output | 1 | One-cycle completion pulse |
| hb_rdata | output | 32 | Assembled read word, valid with hb_done on reads |
| pm_sel | output | 1 | Peripheral cycle strobe |
| pm_we | output | 1 | Peripheral write enable |
| pm_addr | output | ADDR_W | Peripheral byte address (halfword index plus byte bit) |
| pm_be | output | 2 | Lane enables: [1] for [15:8], [0] for [7:0] |
| pm_wdata | output | 16 | Peripheral write data |
| pm_rdata | input | 16 | Peripheral read data, valid with pm_ready |
| pm_ready | input | 1 | Peripheral cycle completion |

## Verification
The embedded assertions check several properties on every cycle. The strobe, address, lanes and write data must hold steady while the peripheral stalls. The done pulse must last one cycle and must follow a ready. An odd peripheral address may only appear with the low-lane enable alone. Disabled write lanes must carry zeros. Other behaviour can only be shown by the bench scenarios against a shadow memory: the exact address and lane order of each cycle train, the wrap at the top of the address space, the assembled read words, requests ignored while busy, and a reset that aborts an access.

// File: rtl/hw_split_pkg.sv
package hw_split_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  localparam int unsigned HOST_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LANES    = NARROW_W / BYTE_W;
  localparam int unsigned IDX_W    = 2;

  localparam logic [IDX_W-1:0] LAST_EVEN = 2'd1;
  localparam logic [IDX_W-1:0] LAST_ODD  = 2'd2;

  localparam logic [LANES-1:0] BE_NONE = 2'b00;
  localparam logic [LANES-1:0] BE_LOW  = 2'b01;
  localparam logic [LANES-1:0] BE_HIGH = 2'b10;
  localparam logic [LANES-1:0] BE_BOTH = 2'b11;

endpackage

// File: rtl/hw_split_seq.sv
module hw_split_seq
  import hw_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_req,
  input  logic              hb_we,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic              pm_ready,
  output logic              accept,
  output logic              fire,
  output logic              odd_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              hb_done,
  output logic              pm_sel,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [LANES-1:0]  pm_be
);

  localparam int unsigned HW_W = ADDR_W - 1;

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_d;
  logic [HW_W-1:0]  base_q;
  logic             we_q;
  logic             last_beat;
  logic [HW_W-1:0]  hw_idx;
  logic             byte_bit;

  assign accept    = (st_q == SEQ_IDLE) && hb_req;
  assign pm_sel    = (st_q == SEQ_RUN);
  assign fire      = pm_sel && pm_ready;
  assign last_beat = odd_q ? (idx_q == LAST_ODD) : (idx_q == LAST_EVEN);
  assign hb_done   = (st_q == SEQ_DONE);

  // next-state process
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (hb_req) begin
          st_d  = SEQ_RUN;
          idx_d = '0;
        end
      end
      SEQ_RUN: begin
        if (fire) begin
          if (last_beat) st_d = SEQ_DONE;
          else           idx_d = idx_q + 1'b1;
        end
      end
      SEQ_DONE: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      odd_q  <= 1'b0;
      we_q   <= 1'b0;
    end else if (accept) begin
      base_q <= hb_addr[ADDR_W-1:1];
      odd_q  <= hb_addr[0];
      we_q   <= hb_we;
    end
  end

  // peripheral address and lane selection
  always_comb begin
    hw_idx   = base_q + HW_W'(idx_q);
    byte_bit = odd_q && (idx_q == '0);
    pm_addr  = '0;
    pm_be    = BE_NONE;
    pm_we    = 1'b0;
    if (pm_sel) begin
      pm_addr = {hw_idx, byte_bit};
      pm_we   = we_q;
      if (odd_q && idx_q == '0)          pm_be = BE_LOW;
      else if (odd_q && idx_q == LAST_ODD) pm_be = BE_HIGH;
      else                               pm_be = BE_BOTH;
    end
  end

  assert_strobe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel && !pm_ready) |=> (pm_sel && $stable(pm_addr) && $stable(pm_be) && $stable(pm_we)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hb_done |=> !hb_done);

  assert_done_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hb_done |-> $past(pm_sel && pm_ready));

  assert_odd_byte_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel && pm_addr[0]) |-> (pm_be == BE_LOW));

  assert_lanes_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_sel |-> (pm_be != BE_NONE));

endmodule

// File: rtl/hw_split_lane.sv
module hw_split_lane
  import hw_split_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                fire,
  input  logic                odd_q,
  input  logic [IDX_W-1:0]    idx_q,
  input  logic                pm_sel,
  input  logic                pm_we,
  input  logic [LANES-1:0]    pm_be,
  input  logic [HOST_W-1:0]   hb_wdata,
  input  logic [NARROW_W-1:0] pm_rdata,
  output logic [NARROW_W-1:0] pm_wdata,
  output logic [HOST_W-1:0]   hb_rdata
);

  logic [HOST_W-1:0]   wdata_q;
  logic [HOST_W-1:0]   hold_q, hold_d;
  logic [NARROW_W-1:0] steer;
  logic                rd_en;

  // write steering: big-endian, host byte 0 is [31:24]
  always_comb begin
    steer = '0;
    if (!odd_q) begin
      steer = (idx_q == '0) ? wdata_q[31:16] : wdata_q[15:0];
    end else begin
      unique case (idx_q)
        2'd0:    steer = {{BYTE_W{1'b0}}, wdata_q[31:24]};
        2'd1:    steer = wdata_q[23:8];
        default: steer = {wdata_q[7:0], {BYTE_W{1'b0}}};
      endcase
    end
    pm_wdata = (pm_sel && pm_we) ? steer : '0;
  end

  // read gathering into the holding word
  assign rd_en = fire && !pm_we;

  always_comb begin
    hold_d = hold_q;
    if (!odd_q) begin
      if (idx_q == '0) hold_d[31:16] = pm_rdata;
      else             hold_d[15:0]  = pm_rdata;
    end else begin
      unique case (idx_q)
        2'd0:    hold_d[31:24] = pm_rdata[7:0];
        2'd1:    hold_d[23:8]  = pm_rdata;
        default: hold_d[7:0]   = pm_rdata[15:8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (accept) begin
      wdata_q <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (rd_en) begin
      hold_q <= hold_d;
    end
  end

  assign hb_rdata = hold_q;

  assert_low_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel && pm_we && !pm_be[0]) |-> (pm_wdata[7:0] == '0));

  assert_high_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel && pm_we && !pm_be[1]) |-> (pm_wdata[15:8] == '0));

  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_sel && !fire) |=> $stable(pm_wdata));

endmodule

// File: rtl/hw_split_bridge.sv
module hw_split_bridge
  import hw_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hb_req,
  input  logic                hb_we,
  input  logic [ADDR_W-1:0]   hb_addr,
  input  logic [HOST_W-1:0]   hb_wdata,
  output logic                hb_done,
  output logic [HOST_W-1:0]   hb_rdata,
  output logic                pm_sel,
  output logic                pm_we,
  output logic [ADDR_W-1:0]   pm_addr,
  output logic [LANES-1:0]    pm_be,
  output logic [NARROW_W-1:0] pm_wdata,
  input  logic [NARROW_W-1:0] pm_rdata,
  input  logic                pm_ready
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept;
  logic             fire;
  logic             odd_q;
  logic [IDX_W-1:0] idx_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1] && rst_n;

  hw_split_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hb_req   (hb_req),
    .hb_we    (hb_we),
    .hb_addr  (hb_addr),
    .pm_ready (pm_ready),
    .accept   (accept),
    .fire     (fire),
    .odd_q    (odd_q),
    .idx_q    (idx_q),
    .hb_done  (hb_done),
    .pm_sel   (pm_sel),
    .pm_we    (pm_we),
    .pm_addr  (pm_addr),
    .pm_be    (pm_be)
  );

  hw_split_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .accept   (accept),
    .fire     (fire),
    .odd_q    (odd_q),
    .idx_q    (idx_q),
    .pm_sel   (pm_sel),
    .pm_we    (pm_we),
    .pm_be    (pm_be),
    .hb_wdata (hb_wdata),
    .pm_rdata (pm_rdata),
    .pm_wdata (pm_wdata),
    .hb_rdata (hb_rdata)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!pm_sel && !hb_done && pm_be == BE_NONE));

endmodule

// File: tb/sim_hw_split_bridge.sv
module sim_hw_split_bridge;

  localparam int AW = 8;
  localparam int NHW = 2 ** (AW - 1);

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    be;
    logic          we;
    logic [15:0]   wd;
    string         tag_a;
    string         tag_w;
  } pexp_t;

  typedef struct {
    logic        we;
    logic [31:0] rd;
    string       tag;
  } dexp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hb_req = 1'b0;
  logic          hb_we = 1'b0;
  logic [AW-1:0] hb_addr = '0;
  logic [31:0]   hb_wdata = '0;
  logic          hb_done;
  logic [31:0]   hb_rdata;
  logic          pm_sel, pm_we;
  logic [AW-1:0] pm_addr;
  logic [1:0]    pm_be;
  logic [15:0]   pm_wdata;
  logic [15:0]   pm_rdata;
  logic          pm_ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stall  = 0;
  int last_fire_cyc = -10;
  bit prev_wait = 0;
  bit prev_done = 0;
  bit mon_en = 0;
  logic [AW-1:0] pw_addr;
  logic [1:0]    pw_be;
  logic          pw_we;
  logic [15:0]   pw_wd;

  pexp_t pq[$];
  dexp_t dq[$];
  logic [7:0] sh [0:2*NHW-1];
  logic [15:0] pm [0:NHW-1];
  bit mem_loaded = 0;
  int wcnt = 0;
  logic rdy_q = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hw_split_bridge #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_done(hb_done), .hb_rdata(hb_rdata), .pm_sel(pm_sel),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_be(pm_be), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata), .pm_ready(pm_ready)
  );

  function automatic logic [15:0] pat(int i);
    return {8'(i * 7 + 3), 8'(i * 13 + 8'h5A)};
  endfunction

  // peripheral model: ready one cycle after the strobe, plus optional stall
  always @(posedge clk) begin
    if (!mem_loaded) begin
      for (int i = 0; i < NHW; i++) pm[i] <= pat(i);
      mem_loaded <= 1;
    end else if (pm_sel && rdy_q && pm_we) begin
      if (pm_be[1]) pm[pm_addr[AW-1:1]][15:8] <= pm_wdata[15:8];
      if (pm_be[0]) pm[pm_addr[AW-1:1]][7:0]  <= pm_wdata[7:0];
    end
    if (!rst_n || !pm_sel || rdy_q) begin
      rdy_q <= 1'b0;
      wcnt  <= 0;
    end else if (wcnt >= stall) begin
      rdy_q <= 1'b1;
      wcnt  <= 0;
    end else begin
      wcnt <= wcnt + 1;
    end
  end
  assign pm_ready = rdy_q;
  assign pm_rdata = rdy_q ? pm[pm_addr[AW-1:1]] : 16'hDEAD;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push_p(logic [AW-1:0] a, logic [1:0] be, logic we, logic [15:0] wd,
                        string ta, string tw);
    pexp_t e;
    e.addr = a; e.be = be; e.we = we; e.wd = wd; e.tag_a = ta; e.tag_w = tw;
    pq.push_back(e);
  endtask

  // driver: computes expectations and drives one host access
  task automatic access(bit we, logic [AW-1:0] a, logic [31:0] w, bit junk);
    logic [AW-2:0] h;
    dexp_t d;
    logic [31:0] rd;
    h = a[AW-1:1];
    if (!a[0]) begin
      push_p({h, 1'b0},          2'b11, we, w[31:16], "R2", "R4");
      push_p({h + 1'b1, 1'b0},   2'b11, we, w[15:0],  "R2", "R4");
    end else begin
      push_p({h, 1'b1},          2'b01, we, {8'h00, w[31:24]}, "R3", "R5");
      push_p({h + 1'b1, 1'b0},   2'b11, we, w[23:8],           "R3", "R5");
      push_p({h + 2'd2, 1'b0},   2'b10, we, {w[7:0], 8'h00},   "R3", "R5");
    end
    rd = {sh[a], sh[AW'(a + 1)], sh[AW'(a + 2)], sh[AW'(a + 3)]};
    if (we) begin
      sh[a] = w[31:24]; sh[AW'(a + 1)] = w[23:16];
      sh[AW'(a + 2)] = w[15:8]; sh[AW'(a + 3)] = w[7:0];
    end
    d.we = we; d.rd = rd; d.tag = a[0] ? "R7" : "R6";
    dq.push_back(d);
    @(negedge clk);
    hb_req = 1; hb_we = we; hb_addr = a; hb_wdata = w;
    @(negedge clk);
    if (junk) begin
      hb_addr = ~a; hb_wdata = ~w; hb_we = ~we;  // R10: must not disturb the access
      repeat (3) @(negedge clk);
    end
    hb_req = 0;
    while (!hb_done) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (pm_sel && pm_ready) begin
        if (pq.size() == 0) begin
          check(0, "R10", "unexpected peripheral cycle at addr", 32'(pm_addr), 0);
        end else begin
          pexp_t e;
          e = pq.pop_front();
          check(pm_addr == e.addr, e.tag_a, "pm_addr", 32'(pm_addr), 32'(e.addr));
          check(pm_be == e.be, e.tag_a, "pm_be", 32'(pm_be), 32'(e.be));
          check(pm_we == e.we, "R11", "pm_we", 32'(pm_we), 32'(e.we));
          if (e.we) check(pm_wdata == e.wd, e.tag_w, "pm_wdata", 32'(pm_wdata), 32'(e.wd));
        end
        last_fire_cyc = cyc;
      end
      if (pm_sel && !pm_ready && prev_wait) begin
        check(pm_addr == pw_addr && pm_be == pw_be && pm_we == pw_we && pm_wdata == pw_wd,
              "R8", "held cycle changed", {pm_addr, pm_be, pm_wdata}, {pw_addr, pw_be, pw_wd});
      end
      prev_wait = pm_sel && !pm_ready;
      pw_addr = pm_addr; pw_be = pm_be; pw_we = pm_we; pw_wd = pm_wdata;
      if (hb_done) begin
        check(!prev_done, "R9", "done longer than one cycle", 1, 0);
        check(cyc == last_fire_cyc + 1, "R9", "done cycle offset",
              32'(cyc - last_fire_cyc), 1);
        if (dq.size() == 0) begin
          check(0, "R10", "unexpected done", 1, 0);
        end else begin
          dexp_t d;
          d = dq.pop_front();
          if (!d.we) check(hb_rdata == d.rd, d.tag, "hb_rdata", hb_rdata, d.rd);
        end
      end
      prev_done = hb_done;
    end else begin
      prev_wait = 0;
      prev_done = 0;
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < NHW; i++) begin
      logic [15:0] v;
      v = pat(i);
      sh[2*i] = v[15:8];
      sh[2*i+1] = v[7:0];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!pm_sel && !hb_done && pm_be == 2'b00, "R1", "idle after reset",
          {pm_sel, hb_done, pm_be}, 0);
    mon_en = 1;

    access(0, 8'h10, 0, 0);              // R2 R6 even read
    access(0, 8'h21, 0, 0);              // R3 R7 odd read
    access(1, 8'h40, 32'h11223344, 0);   // R4 even write
    access(0, 8'h40, 0, 0);
    access(1, 8'h51, 32'hA1B2C3D4, 0);   // R5 odd write, lane isolation
    access(0, 8'h51, 0, 0);
    access(0, 8'h50, 0, 0);
    access(0, 8'h52, 0, 0);
    stall = 2;                           // R8 stalled peripheral
    access(0, 8'h33, 0, 0);
    access(1, 8'h62, 32'h0F1E2D3C, 0);
    access(1, 8'h67, 32'h55667788, 1);   // R10 junk while busy
    stall = 0;
    access(0, 8'h62, 0, 1);
    access(0, 8'h66, 0, 0);
    access(0, 8'hFF, 0, 0);              // R3 wrap at top
    access(1, 8'hFD, 32'hCAFEBABE, 0);
    access(0, 8'hFC, 0, 0);
    access(0, 8'h00, 0, 0);

    // R1: reset in the middle of an access
    @(negedge clk);
    hb_req = 1; hb_we = 0; hb_addr = 8'h81;
    @(negedge clk);
    hb_req = 0;
    @(negedge clk);
    mon_en = 0;
    rst_n = 0;
    #1;
    check(!pm_sel && !hb_done && pm_be == 2'b00, "R1", "idle on mid-access reset",
          {pm_sel, hb_done, pm_be}, 0);
    pq.delete();
    dq.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!pm_sel && !hb_done, "R1", "still idle after release", {pm_sel, hb_done}, 0);
    mon_en = 1;
    access(0, 8'h81, 0, 0);
    access(0, 8'h40, 0, 0);

    repeat (5) @(negedge clk);
    check(pq.size() == 0 && dq.size() == 0, "R10", "expected items left over",
          32'(pq.size() + dq.size()), 0);
    finish_up();
  end

endmodule